// File: doc/BRIEF.md
# Interrupt Status and Mask Register Slave

This block is a word-wide register slave that gathers ten interrupt causes into one level interrupt line. Each cause has a sticky status bit. Two sources can set a status bit: a per-bit hardware set input and a software force command. Software clears a status bit by writing a 1 to it. The mask is never written directly. Software changes it only through two command offsets: one clears mask bits and one sets them. Every cause starts masked after reset.

The same slave also holds a small control register and a read-only engine flag word. Writing the control register with its scan-start bit at 1 sets both the scan-done flag and the scan-ok flag. An init-done flag in that word is already set when reset is released. The bus is a simple synchronous interface with word accesses only. A write takes effect at the clock edge that closes its request cycle. Read data is registered.

Top module: `irqm_top`

## Requirements
- R1: After reset, status (offset 0) reads 0x000, mask (offset 1) reads 0x3FF, the engine flag word (offset 6) reads 0x1, and irq_o is low.
- R2: A write to offset 0 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R3: A write to offset 2 clears each mask bit whose write-data bit is 1. All other mask bits are unchanged.
- R4: A write to offset 3 sets each mask bit whose write-data bit is 1. All other mask bits are unchanged.
- R5: A write to offset 4 sets each status bit whose write-data bit is 1.
- R6: irq_o is high exactly when some status bit is 1 while its mask bit is 0. It changes in the cycle after the write or hardware set that causes the change.
- R7: The following are true of reads and direct writes:
  - Bits 31:10 of status and mask reads are zero.
  - Offsets 2, 3 and 4 read as zero.
  - A direct write to offset 1 leaves the mask unchanged.
  - No read drives any bit above bit 14.
- R8: A 1 on hw_set_i[n] sets status bit n. If a clear write to bit n happens in the same cycle, the hardware set wins.
- R9: A write to the control register (offset 5, 15 bits, read back as written) with bit 0 at 1 sets engine flag bit 1 (scan done) and bit 2 (scan ok). A control write with bit 0 at 0 leaves the flags unchanged.
- R10: Read data appears on rdata_o in the cycle after the read request and holds until the next read. Unmapped offsets (7) read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 3 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| hw_set_i | input | 10 | Per-cause hardware set pulses |
| irq_o | output | 1 | Level interrupt output |

## Verification
A write, or a hardware set pulse, that is present in cycle k changes status, mask, flags and irq_o at the edge that ends cycle k. Those values are therefore seen in cycle k+1. A read requested in cycle k puts its data on rdata_o in cycle k+1. The bench drives every request on a falling edge and samples on the next falling edge, which is one rising edge later. For the timing of irq_o it also samples in the request cycle itself, to show that the old level is still present. The hardware-over-software priority is tested by presenting a set pulse and a clearing write in the same cycle.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    // Default geometry of the slave
    localparam int unsigned NUM_SRC  = 10;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned CTRL_W   = 15;
    localparam int unsigned NUM_REGS = 7;

    // Word offsets of the register map
    localparam int unsigned OFF_STATUS  = 0;
    localparam int unsigned OFF_MASK    = 1;
    localparam int unsigned OFF_UNMASK  = 2;
    localparam int unsigned OFF_MASKSET = 3;
    localparam int unsigned OFF_FORCE   = 4;
    localparam int unsigned OFF_CTRL    = 5;
    localparam int unsigned OFF_ENGINE  = 6;

    // Engine flag word bits and control trigger bit
    localparam int unsigned FLAG_W     = 3;
    localparam int unsigned FLAG_INIT  = 0;
    localparam int unsigned FLAG_DONE  = 1;
    localparam int unsigned FLAG_PASS  = 2;
    localparam int unsigned SCAN_BIT   = 0;
endpackage

// File: rtl/irqm_decode.sv
module irqm_decode #(
    parameter int unsigned ADDR_W   = irqm_pkg::ADDR_W,
    parameter int unsigned NUM_REGS = irqm_pkg::NUM_REGS
) (
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [NUM_REGS-1:0] wr_sel_o,
    output logic                rd_en_o
);
    // One write strobe per mapped offset
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wr_sel_o[g] = req_i & we_i & (addr_i == ADDR_W'(g));
    end

    assign rd_en_o = req_i & ~we_i;
endmodule

// File: rtl/irqm_core.sv
module irqm_core #(
    parameter int unsigned NUM_SRC = irqm_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_clear_i,
    input  logic               wr_unmask_i,
    input  logic               wr_maskset_i,
    input  logic               wr_force_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] hw_set_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] mask;
        logic               irq;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Software clear first, then sets, so hardware set wins a collision
        if (wr_clear_i) begin
            st_d.status = st_d.status & ~wdata_i;
        end
        if (wr_force_i) begin
            st_d.status = st_d.status | wdata_i;
        end
        st_d.status = st_d.status | hw_set_i;
        if (wr_unmask_i) begin
            st_d.mask = st_d.mask & ~wdata_i;
        end
        if (wr_maskset_i) begin
            st_d.mask = st_d.mask | wdata_i;
        end
        st_d.irq = |(st_d.status & ~st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/irqm_scan.sv
module irqm_scan #(
    parameter int unsigned CTRL_W   = irqm_pkg::CTRL_W,
    parameter int unsigned SCAN_BIT = irqm_pkg::SCAN_BIT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_ctrl_i,
    input  logic [CTRL_W-1:0]            wdata_i,
    output logic [CTRL_W-1:0]            ctrl_o,
    output logic [irqm_pkg::FLAG_W-1:0]  flags_o
);
    import irqm_pkg::*;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [FLAG_W-1:0] flags;
    } scan_state_t;

    scan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl_i) begin
            st_d.ctrl = wdata_i;
            if (wdata_i[SCAN_BIT]) begin
                st_d.flags[FLAG_DONE] = 1'b1;
                st_d.flags[FLAG_PASS] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl             <= '0;
            st_q.flags            <= '0;
            st_q.flags[FLAG_INIT] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/irqm_top.sv
module irqm_top #(
    parameter int unsigned NUM_SRC = irqm_pkg::NUM_SRC,
    parameter int unsigned DATA_W  = irqm_pkg::DATA_W,
    parameter int unsigned ADDR_W  = irqm_pkg::ADDR_W,
    parameter int unsigned CTRL_W  = irqm_pkg::CTRL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_SRC-1:0] hw_set_i,
    output logic               irq_o
);
    import irqm_pkg::*;

    logic [NUM_REGS-1:0] wr_sel;
    logic                rd_en;
    logic [NUM_SRC-1:0]  status_w;
    logic [NUM_SRC-1:0]  mask_w;
    logic [CTRL_W-1:0]   ctrl_w;
    logic [FLAG_W-1:0]   flags_w;

    wire unused_wdata_hi = ^wdata_i[DATA_W-1:CTRL_W];

    irqm_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .req_i    (req_i),
        .we_i     (we_i),
        .addr_i   (addr_i),
        .wr_sel_o (wr_sel),
        .rd_en_o  (rd_en)
    );

    irqm_core #(.NUM_SRC(NUM_SRC)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_clear_i   (wr_sel[OFF_STATUS]),
        .wr_unmask_i  (wr_sel[OFF_UNMASK]),
        .wr_maskset_i (wr_sel[OFF_MASKSET]),
        .wr_force_i   (wr_sel[OFF_FORCE]),
        .wdata_i      (wdata_i[NUM_SRC-1:0]),
        .hw_set_i     (hw_set_i),
        .status_o     (status_w),
        .mask_o       (mask_w),
        .irq_o        (irq_o)
    );

    irqm_scan #(.CTRL_W(CTRL_W), .SCAN_BIT(SCAN_BIT)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_sel[OFF_CTRL]),
        .wdata_i   (wdata_i[CTRL_W-1:0]),
        .ctrl_o    (ctrl_w),
        .flags_o   (flags_w)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        if (rd_en) begin
            case (addr_i)
                ADDR_W'(OFF_STATUS): bs_d.rdata = DATA_W'(status_w);
                ADDR_W'(OFF_MASK):   bs_d.rdata = DATA_W'(mask_w);
                ADDR_W'(OFF_CTRL):   bs_d.rdata = DATA_W'(ctrl_w);
                ADDR_W'(OFF_ENGINE): bs_d.rdata = DATA_W'(flags_w);
                default:             bs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign rdata_o = bs_q.rdata;
endmodule

// File: rtl/irqm_checker.sv
module irqm_checker #(
    parameter int unsigned NUM_SRC = irqm_pkg::NUM_SRC,
    parameter int unsigned DATA_W  = irqm_pkg::DATA_W,
    parameter int unsigned ADDR_W  = irqm_pkg::ADDR_W,
    parameter int unsigned CTRL_W  = irqm_pkg::CTRL_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req,
    input logic                        we,
    input logic [ADDR_W-1:0]           addr,
    input logic [DATA_W-1:0]           wdata,
    input logic [DATA_W-1:0]           rdata,
    input logic [NUM_SRC-1:0]          hw_set,
    input logic                        irq,
    input logic [NUM_SRC-1:0]          status,
    input logic [NUM_SRC-1:0]          mask,
    input logic [irqm_pkg::FLAG_W-1:0] flags
);
    import irqm_pkg::*;

    logic               wr;
    logic               mask_cmd;
    logic               force_wr;
    logic               scan_wr;
    logic [NUM_SRC-1:0] clr_allow;

    assign wr        = req && we;
    assign mask_cmd  = wr && (addr == ADDR_W'(OFF_UNMASK) || addr == ADDR_W'(OFF_MASKSET));
    assign force_wr  = wr && (addr == ADDR_W'(OFF_FORCE));
    assign scan_wr   = wr && (addr == ADDR_W'(OFF_CTRL)) && wdata[SCAN_BIT];
    assign clr_allow = (wr && addr == ADDR_W'(OFF_STATUS)) ? wdata[NUM_SRC-1:0] : '0;

    // R2: a status bit only falls when a clearing write named it
    assert_status_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status) & ~$past(clr_allow)) == '0);

    // R3, R4, R7: mask moves only through the two command offsets
    assert_mask_cmd_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask != $past(mask)) |-> $past(mask_cmd));

    // R5: forced bits are set afterwards
    assert_force_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> ((status & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

    // R6: interrupt level agrees with pending unmasked causes
    assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status & ~mask));

    // R7: no read drives bits above the widest register
    assert_rdata_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CTRL_W] == '0);

    // R8: a hardware set always lands
    assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((status & $past(hw_set)) == $past(hw_set)));

    // R9: scan trigger raises both result flags
    assert_scan_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_wr |=> (flags[FLAG_DONE] && flags[FLAG_PASS]));
endmodule

bind irqm_top irqm_checker #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CTRL_W  (CTRL_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_i),
    .we     (we_i),
    .addr   (addr_i),
    .wdata  (wdata_i),
    .rdata  (rdata_o),
    .hw_set (hw_set_i),
    .irq    (irq_o),
    .status (status_w),
    .mask   (mask_w),
    .flags  (flags_w)
);

// File: tb/sim_irqm_top.sv
module sim_irqm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [9:0]  hw_set = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irqm_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .hw_set_i (hw_set),
        .irq_o    (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 status", v, 32'h0);
        rd(3'd1, v); check("R1 mask", v, 32'h3FF);
        rd(3'd6, v); check("R1 engine flags", v, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_force_clear();
        logic [31:0] v;
        wr(3'd4, 32'h005);
        rd(3'd0, v); check("R5 force", v, 32'h005);
        check("R6 masked irq low", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h004);
        rd(3'd0, v); check("R2 w1c", v, 32'h001);
        wr(3'd0, 32'h000);
        rd(3'd0, v); check("R2 write zero", v, 32'h001);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(3'd2, 32'h003);
        rd(3'd1, v); check("R3 unmask", v, 32'h3FC);
        check("R6 irq high", {31'b0, irq}, 32'h1);
        wr(3'd3, 32'h001);
        rd(3'd1, v); check("R4 maskset", v, 32'h3FD);
        check("R6 irq low again", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h000);
        rd(3'd1, v); check("R7 direct mask write ignored", v, 32'h3FD);
        rd(3'd2, v); check("R7 unmask reads zero", v, 32'h0);
        rd(3'd3, v); check("R7 maskset reads zero", v, 32'h0);
        rd(3'd4, v); check("R7 force reads zero", v, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R7 status reserved zero", v, 32'h3FF);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R2 clear all", v, 32'h0);
    endtask

    task automatic t_irq_timing();
        // mask is 0x3FD: bit1 unmasked
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 3'd4; wdata = 32'h002;
        #1 check("R6 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        req = 1'b0; we = 1'b0; wdata = '0;
        check("R6 irq next cycle", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h002);
        check("R6 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_hw_priority();
        logic [31:0] v;
        @(negedge clk);
        hw_set = 10'h004;
        @(negedge clk);
        hw_set = '0;
        rd(3'd0, v); check("R8 hw set", v, 32'h004);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 3'd0; wdata = 32'h00C; hw_set = 10'h008;
        @(negedge clk);
        req = 1'b0; we = 1'b0; wdata = '0; hw_set = '0;
        rd(3'd0, v); check("R8 hw wins over clear", v, 32'h008);
        wr(3'd0, 32'h008);
    endtask

    task automatic t_scan();
        logic [31:0] v;
        wr(3'd5, 32'h0002);
        rd(3'd6, v); check("R9 no trigger keeps flags", v, 32'h1);
        rd(3'd5, v); check("R9 ctrl readback", v, 32'h0002);
        wr(3'd5, 32'hFFFF_0003);
        rd(3'd6, v); check("R9 trigger sets flags", v, 32'h7);
        rd(3'd5, v); check("R9 ctrl readback masked", v, 32'h0003);
    endtask

    task automatic t_bus();
        logic [31:0] v;
        rd(3'd1, v); check("R10 mask read", v, 32'h3FD);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 3'd7;
        #1 check("R10 old data held", rdata, 32'h3FD);
        @(negedge clk);
        req = 1'b0;
        check("R10 unmapped reads zero", rdata, 32'h0);
        repeat (2) @(negedge clk);
        check("R10 data held with no read", rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_force_clear();
        t_mask();
        t_irq_timing();
        t_hw_priority();
        t_scan();
        t_bus();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule